// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block steps through the column addresses of one read or write burst within an open SDRAM row. A start strobe captures a start column, a burst-length code and an ordering type. From the next clock the block presents one column address per cycle with a valid flag, and it raises a last-beat flag on the final beat of a fixed-length burst. A controller uses this sequence to drive the column phase of its read and write commands.

Two orderings are available. The sequential order wraps inside an aligned block of BL columns. The interleaved order XORs the beat index into the low address bits. A full-page sequential mode runs through the whole 256-column row and continues until it is stopped. A terminate input cuts a burst short. A new start on any cycle replaces the running burst at once. If full page is requested together with interleave, the block runs an 8-beat interleaved burst and raises an error flag.

Top module: `sdram_col_burst_gen`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o`, `last_o` and `cfg_err_o` are 0 until a start is accepted.
- R2: A start sampled on a clock edge makes `valid_o` 1 and `col_o` equal to the sampled `start_col_i` in the following cycle. This is beat 0.
- R3: With `type_i`=0 (sequential) and length BL in {2,4,8}, beat b outputs the start column with its upper bits unchanged and its low log2(BL) bits equal to (start low bits + b) mod BL.
- R4: With `type_i`=1 (interleave), beat b outputs the start column XOR b, for b < BL.
- R5: `bl_sel_i` codes 0, 1, 2 and 3 select BL = 1, 2, 4 and 8. Such a burst shows exactly BL valid beats. `last_o` is 1 only on beat BL-1, and `valid_o` is 0 in the cycle after that beat unless a new start was accepted.
- R6: `bl_sel_i` codes 4 to 7 with `type_i`=0 select full page. Beat b outputs (start + b) mod 256, `valid_o` stays 1, and `last_o` is never 1.
- R7: `term_i` sampled with `valid_o`=1 and no start makes `valid_o` and `last_o` 0 in the next cycle. `term_i` while idle has no effect.
- R8: A start accepted during a running burst replaces it. The next cycle shows beat 0 of the new burst with the new configuration.
- R9: A start with `type_i`=1 and a full-page code runs as an 8-beat interleaved burst and sets `cfg_err_o`. Every later start reloads `cfg_err_o`, so a legal start clears it. `cfg_err_o` does not change between starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a new burst (takes priority over terminate) |
| start_col_i | input | 8 | Start column of the burst |
| bl_sel_i | input | 3 | Length code: 0..3 give 1/2/4/8 beats, 4..7 give full page |
| type_i | input | 1 | Ordering: 0 sequential, 1 interleave |
| term_i | input | 1 | Stop the running burst |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | `col_o` holds a burst beat |
| last_o | output | 1 | Current beat is the final one of a fixed-length burst |
| cfg_err_o | output | 1 | Last start requested full page with interleave |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. Beat 0 and the error flag follow a start by one edge, and each later beat follows the previous one by one edge. The drop of `valid_o` follows either the last beat or a terminate by one edge. The bench drives inputs on the falling edge. At each falling edge it compares the outputs with the value it expects for the beat reached, counting one beat per rising edge since the start. It then drives the next input on that same falling edge, so the sampling cycle of every check follows directly from the beat count.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  localparam int BL_SEL_W = 3;
  localparam int ILV_MAX_LOG2 = 3;
  typedef enum logic {
    BT_SEQ = 1'b0,
    BT_ILV = 1'b1
  } burst_type_e;
endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [BL_SEL_W-1:0] bl_sel_i,
  input  logic                type_i,
  output logic [COL_W-1:0]    mask_o,
  output logic                full_o,
  output logic                ilv_o,
  output logic                err_o
);
  localparam logic [COL_W-1:0] ILV_MAX_MASK = COL_W'((1 << ILV_MAX_LOG2) - 1);

  logic full_req;
  assign full_req = bl_sel_i[BL_SEL_W-1];

  always_comb begin
    err_o  = 1'b0;
    full_o = 1'b0;
    ilv_o  = (burst_type_e'(type_i) == BT_ILV);
    mask_o = COL_W'((COL_W'(1) << bl_sel_i[1:0]) - COL_W'(1));
    if (full_req && ilv_o) begin
      // illegal: fall back to 8-beat interleave
      err_o  = 1'b1;
      mask_o = ILV_MAX_MASK;
    end else if (full_req) begin
      full_o = 1'b1;
      mask_o = '1;
    end
  end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  input  logic             err_i,
  output logic             active_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             ilv_o,
  output logic             err_o
);
  logic end_beat;
  assign end_beat = !full_o && (beat_o == mask_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      beat_o   <= '0;
      base_o   <= '0;
      mask_o   <= '0;
      full_o   <= 1'b0;
      ilv_o    <= 1'b0;
      err_o    <= 1'b0;
    end else if (start_i) begin
      active_o <= 1'b1;
      beat_o   <= '0;
      base_o   <= start_col_i;
      mask_o   <= mask_i;
      full_o   <= full_i;
      ilv_o    <= ilv_i;
      err_o    <= err_i;
    end else if (active_o) begin
      if (term_i || end_beat) active_o <= 1'b0;
      else beat_o <= beat_o + COL_W'(1);
    end
  end
endmodule

// File: rtl/burst_col_calc.sv
module burst_col_calc #(
  parameter int COL_W = 8
) (
  input  logic             active_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);
  logic [COL_W-1:0] seq_col, ilv_col, sum;

  assign sum     = base_i + beat_i;
  // full page: mask is all ones, so this wraps over the whole row
  assign seq_col = (base_i & ~mask_i) | (sum & mask_i);
  assign ilv_col = base_i ^ (beat_i & mask_i);
  assign col_o   = ilv_i ? ilv_col : seq_col;
  assign last_o  = active_i && !full_i && (beat_i == mask_i);
endmodule

// File: rtl/sdram_col_burst_gen.sv
module sdram_col_burst_gen
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [COL_W-1:0]    start_col_i,
  input  logic [BL_SEL_W-1:0] bl_sel_i,
  input  logic                type_i,
  input  logic                term_i,
  output logic [COL_W-1:0]    col_o,
  output logic                valid_o,
  output logic                last_o,
  output logic                cfg_err_o
);
  logic [COL_W-1:0] dec_mask, beat_q, base_q, mask_q;
  logic dec_full, dec_ilv, dec_err, active_q, full_q, ilv_q;

  burst_cfg_decode #(.COL_W(COL_W)) u_dec (
    .bl_sel_i (bl_sel_i),
    .type_i   (type_i),
    .mask_o   (dec_mask),
    .full_o   (dec_full),
    .ilv_o    (dec_ilv),
    .err_o    (dec_err)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .term_i      (term_i),
    .start_col_i (start_col_i),
    .mask_i      (dec_mask),
    .full_i      (dec_full),
    .ilv_i       (dec_ilv),
    .err_i       (dec_err),
    .active_o    (active_q),
    .beat_o      (beat_q),
    .base_o      (base_q),
    .mask_o      (mask_q),
    .full_o      (full_q),
    .ilv_o       (ilv_q),
    .err_o       (cfg_err_o)
  );

  burst_col_calc #(.COL_W(COL_W)) u_calc (
    .active_i (active_q),
    .beat_i   (beat_q),
    .base_i   (base_q),
    .mask_i   (mask_q),
    .full_i   (full_q),
    .ilv_i    (ilv_q),
    .col_o    (col_o),
    .last_o   (last_o)
  );

  assign valid_o = active_q;
endmodule

// File: rtl/sdram_col_burst_chk.sv
module sdram_col_burst_chk #(
  parameter int COL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       bl_sel_i,
  input logic             type_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             cfg_err_o
);
  p_idle_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && !start_i |=> !valid_o);

  p_first_beat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && col_o == $past(start_col_i));

  p_last_is_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  p_last_ends_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !valid_o);

  p_full_no_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !type_i && bl_sel_i[2] |=> !last_o);

  p_term_stops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_i && !start_i |=> !valid_o && !last_o);

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && start_i |=> valid_o && col_o == $past(start_col_i));

  p_err_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cfg_err_o == ($past(type_i) && $past(bl_sel_i[2])));

  p_err_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(cfg_err_o));
endmodule

bind sdram_col_burst_gen sdram_col_burst_chk #(.COL_W(COL_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .bl_sel_i    (bl_sel_i),
  .type_i      (type_i),
  .term_i      (term_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/sdram_col_burst_gen_tb_top.sv
module sdram_col_burst_gen_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] bl_sel_i = '0;
  logic       type_i = 1'b0;
  logic       term_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o, last_o, cfg_err_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk_i = ~clk_i;

  sdram_col_burst_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .start_col_i(start_col_i),
    .bl_sel_i(bl_sel_i), .type_i(type_i), .term_i(term_i), .col_o(col_o),
    .valid_o(valid_o), .last_o(last_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bl_of(input int sel, input int typ);
    if (sel >= 4) return (typ != 0) ? 8 : 0;  // 0 means full page
    return 1 << sel;
  endfunction

  function automatic int exp_col(input int base, input int b, input int sel, input int typ);
    int bl = bl_of(sel, typ);
    int m;
    if (bl == 0) return (base + b) % 256;
    m = bl - 1;
    if (typ != 0) return base ^ b;
    return (base & ~m & 255) | ((base + b) & m);
  endfunction

  // called on a falling edge; returns on the falling edge showing beat 0
  task automatic launch(input int c, input int sel, input int typ);
    start_i = 1'b1; start_col_i = 8'(c); bl_sel_i = 3'(sel); type_i = typ[0];
    @(negedge clk_i);
    start_i = 1'b0;
    chk(cfg_err_o == ((typ != 0) && sel >= 4), "R9 err flag", int'(cfg_err_o),
        int'((typ != 0) && sel >= 4));
  endtask

  task automatic beats(input int base, input int sel, input int typ, input int n);
    int bl = bl_of(sel, typ);
    for (int b = 0; b < n; b++) begin
      int e = exp_col(base, b, sel, typ);
      bit el = (bl != 0) && (b == bl - 1);
      chk(valid_o == 1'b1, "R5 valid in burst", int'(valid_o), 1);
      chk(int'(col_o) == e, (typ != 0) ? "R4 interleave col" : (bl == 0 ? "R6 full col" : "R3 seq col"),
          int'(col_o), e);
      chk(last_o == el, (bl == 0) ? "R6 no last" : "R5 last beat", int'(last_o), int'(el));
      @(negedge clk_i);
    end
  endtask

  task automatic idle(input string req);
    chk(valid_o == 1'b0, req, int'(valid_o), 0);
    chk(last_o == 1'b0, req, int'(last_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    idle("R1 in reset");
    chk(cfg_err_o == 1'b0, "R1 err in reset", int'(cfg_err_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle("R1 after reset");

    // R7: terminate while idle is ignored
    term_i = 1'b1;
    @(negedge clk_i);
    term_i = 1'b0;
    idle("R7 term idle");

    // R2 R3 R4 R5: sweep every start column, fixed lengths, both types
    for (int c = 0; c < 256; c++)
      for (int sel = 0; sel < 4; sel++)
        for (int typ = 0; typ < 2; typ++) begin
          launch(c, sel, typ);
          chk(int'(col_o) == c, "R2 first beat", int'(col_o), c);
          beats(c, sel, typ, 1 << sel);
          idle("R5 end of burst");
        end

    // R6: full page wraps over the row, every full-page code
    for (int sel = 4; sel < 8; sel++) begin
      launch(250 - sel, sel, 0);
      beats(250 - sel, sel, 0, 300);
      term_i = 1'b1;
      @(negedge clk_i);
      term_i = 1'b0;
      idle("R7 term full page");
    end

    // R7: terminate a fixed burst midway
    launch(16, 3, 0);
    beats(16, 3, 0, 3);
    term_i = 1'b1;
    @(negedge clk_i);
    term_i = 1'b0;
    idle("R7 term mid burst");

    // R8: restart during a burst, also with a terminate on the same edge
    launch(10, 3, 0);
    beats(10, 3, 0, 3);
    term_i = 1'b1;
    launch(200, 2, 1);
    term_i = 1'b0;
    chk(int'(col_o) == 200, "R8 restart col", int'(col_o), 200);
    beats(200, 2, 1, 4);
    idle("R8 end after restart");

    // R9: illegal combination behaves as 8-beat interleave, then clears
    for (int sel = 4; sel < 8; sel++) begin
      launch(8'h35, sel, 1);
      beats(8'h35, sel, 1, 8);
      idle("R9 illegal ends after 8");
      chk(cfg_err_o == 1'b1, "R9 err held", int'(cfg_err_o), 1);
    end
    launch(8'h35, 1, 0);
    beats(8'h35, 1, 0, 2);
    chk(cfg_err_o == 1'b0, "R9 err cleared", int'(cfg_err_o), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule